// File: doc/BRIEF.md
# Grid Cell Stream Receiver with Alternating-Sign Checksum

This block sits behind a byte-wide receive path, after the serial deframer, and takes in one square puzzle grid at a time. The grid side length `GRID_N` is a build-time parameter. Each cell arrives as one byte, and the cells come in row-major order starting at the top-left corner. A zero byte marks an empty cell and is stored as zero. For every cell, the block issues a one-cycle write (address and data) toward an external grid memory. It also folds the cell into an 8-bit checksum: the cell value is added when its row index plus column index is even, and subtracted when that sum is odd.

After the last cell, the very next byte is the sender's checksum. The block compares that byte with the low 8 bits of its own running total. It then raises `done` for one cycle and presents the result on `chk_ok`. The block then goes idle and ignores all traffic until the next `start` pulse. `start` clears all position and sum state and opens a new frame.

The sign is tracked by a toggle bit, not by adding row and column. The sign flips from each cell to the next. At the start of every row, the sign is the opposite of the sign the previous row started with.

Top module: `grid_checksum_rx`

## Requirements
- R1: After reset, `wr_en`, `done` and `chk_ok` are low and the block is idle: bytes presented with `in_valid` produce no write and no `done` until `start` is pulsed.
- R2: A cycle with `start` high clears the cell position, the running sum and `chk_ok` (low from the next cycle), and opens a new frame. `start` overrides a byte presented in the same cycle, which is dropped. A `start` in the middle of a frame restarts the frame at cell 0.
- R3: During the cell phase, a byte accepted at a clock edge gives `wr_en` high for exactly the following cycle. In that cycle, `wr_addr` = row*GRID_N + col (row 0, col 0 is the top-left cell, address 0) and `wr_data` equals the byte unchanged.
- R4: A cell at row r, column c is added to the checksum when r+c is even and subtracted when r+c is odd, modulo 256. The first cell of each row therefore takes the sign opposite to the first cell of the previous row, for both odd and even `GRID_N`.
- R5: The byte that follows cell GRID_N*GRID_N-1 is taken as the checksum. It causes no write.
- R6: One cycle after the checksum byte is accepted, `done` is high for exactly one cycle and `chk_ok` is 1 exactly when that byte equals the low 8 bits of the running sum. `chk_ok` then holds its value until the next `start`.
- R7: After the checksum byte, the block is idle again: further bytes cause no write and no `done` until `start`.
- R8: A grid whose cells are all empty (all zero bytes) has checksum 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that clears state and opens a frame |
| in_valid | input | 1 | A received byte is present on `in_data` |
| in_data | input | 8 | Received byte (cell value or checksum) |
| wr_en | output | 1 | Write strobe toward grid memory |
| wr_addr | output | ADDR_W | Row-major cell index of the write |
| wr_data | output | 8 | Cell value to store |
| done | output | 1 | One-cycle pulse after the checksum byte |
| chk_ok | output | 1 | Received checksum matched the computed one |

## Verification
The bench runs with an even side length. On an even grid, letting the sign keep toggling across a row boundary gives the wrong sign to every cell of every odd row. A grid with one nonzero cell at the start of row 1 exposes that, because the expected checksum then flips. An all-empty grid is checked against checksums of 0x00 and 0x01, which catches a design that reports a match without comparing. A `start` arriving in the same cycle as a byte, or in the middle of a frame, would shift every later address by one if the byte leaked through or the counters were not cleared. Stray bytes after `done` would produce spurious writes or a second `done` if the block did not return to idle.

// File: rtl/grid_ck_pkg.sv
package grid_ck_pkg;

    localparam int CELL_W = 8;
    localparam int CK_W   = 8;

    typedef logic [CELL_W-1:0] cell_t;
    typedef logic [CK_W-1:0]   ck_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CELLS = 2'd1,
        PH_CHECK = 2'd2
    } phase_e;

    typedef struct packed {
        logic clear;
        logic cell_take;
        logic ck_take;
    } rx_ctrl_t;

    typedef struct packed {
        logic  en;
        cell_t data;
    } wr_beat_t;

    function automatic int unsigned idx_bits(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

    function automatic ck_t fold_cell(input ck_t acc, input cell_t v, input logic neg);
        return neg ? ck_t'(acc - ck_t'(v)) : ck_t'(acc + ck_t'(v));
    endfunction

endpackage

// File: rtl/grid_frame_ctrl.sv
module grid_frame_ctrl
    import grid_ck_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     in_valid,
    input  logic     last_cell,
    output rx_ctrl_t ctrl
);

    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        ctrl       = '0;
        ctrl.clear = start;
        if (!start && in_valid) begin
            case (phase_q)
                PH_CELLS: ctrl.cell_take = 1'b1;
                PH_CHECK: ctrl.ck_take   = 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        phase_d = phase_q;
        if (start) begin
            phase_d = PH_CELLS;
        end else begin
            case (phase_q)
                PH_CELLS: if (ctrl.cell_take && last_cell) phase_d = PH_CHECK;
                PH_CHECK: if (ctrl.ck_take) phase_d = PH_IDLE;
                PH_IDLE:  phase_d = PH_IDLE;
                default:  phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

endmodule

// File: rtl/grid_pos_tracker.sv
module grid_pos_tracker
    import grid_ck_pkg::*;
#(
    parameter int GRID_N = 9,
    parameter int IDX_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             neg,
    output logic             last
);

    localparam int RC_W = idx_bits(GRID_N);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(GRID_N - 1);

    logic [RC_W-1:0] row_q;
    logic [RC_W-1:0] col_q;
    logic            row_start_neg_q;
    logic            row_end;

    assign row_end = (col_q == RC_LAST);
    assign last    = row_end && (row_q == RC_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx             <= '0;
            row_q           <= '0;
            col_q           <= '0;
            neg             <= 1'b0;
            row_start_neg_q <= 1'b0;
        end else if (step) begin
            idx <= idx + IDX_W'(1);
            if (row_end) begin
                col_q           <= '0;
                row_q           <= row_q + RC_W'(1);
                neg             <= ~row_start_neg_q;
                row_start_neg_q <= ~row_start_neg_q;
            end else begin
                col_q <= col_q + RC_W'(1);
                neg   <= ~neg;
            end
        end
    end

endmodule

// File: rtl/grid_sum_acc.sv
module grid_sum_acc
    import grid_ck_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  add_en,
    input  logic  neg,
    input  cell_t value,
    output ck_t   sum
);

    always_ff @(posedge clk) begin
        if (rst || clear) sum <= '0;
        else if (add_en)  sum <= fold_cell(sum, value, neg);
    end

endmodule

// File: rtl/grid_checksum_rx.sv
module grid_checksum_rx
    import grid_ck_pkg::*;
#(
    parameter  int GRID_N = 9,
    localparam int CELLS  = GRID_N * GRID_N,
    localparam int ADDR_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              chk_ok
);

    rx_ctrl_t          ctrl;
    logic [ADDR_W-1:0] cell_idx;
    logic              cell_neg;
    logic              cell_last;
    ck_t               run_sum;
    wr_beat_t          beat_q;

    grid_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .last_cell (cell_last),
        .ctrl      (ctrl)
    );

    grid_pos_tracker #(
        .GRID_N (GRID_N),
        .IDX_W  (ADDR_W)
    ) u_pos (
        .clk   (clk),
        .rst   (rst),
        .clear (ctrl.clear),
        .step  (ctrl.cell_take),
        .idx   (cell_idx),
        .neg   (cell_neg),
        .last  (cell_last)
    );

    grid_sum_acc u_sum (
        .clk    (clk),
        .rst    (rst),
        .clear  (ctrl.clear),
        .add_en (ctrl.cell_take),
        .neg    (cell_neg),
        .value  (cell_t'(in_data)),
        .sum    (run_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            wr_addr <= '0;
            done    <= 1'b0;
            chk_ok  <= 1'b0;
        end else begin
            beat_q.en <= ctrl.cell_take;
            if (ctrl.cell_take) begin
                beat_q.data <= cell_t'(in_data);
                wr_addr     <= cell_idx;
            end
            done <= ctrl.ck_take;
            if (ctrl.clear)        chk_ok <= 1'b0;
            else if (ctrl.ck_take) chk_ok <= (ck_t'(in_data) == run_sum);
        end
    end

    assign wr_en   = beat_q.en;
    assign wr_data = beat_q.data;

endmodule

// File: rtl/grid_checksum_rx_chk.sv
module grid_checksum_rx_chk #(
    parameter  int GRID_N = 9,
    localparam int CELLS  = GRID_N * GRID_N,
    localparam int ADDR_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              in_valid,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done,
    input logic              chk_ok
);

    // R6: done lasts one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: done follows an accepted byte that start did not override
    assert_done_cause_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(in_valid) && !$past(start)));

    // R6: chk_ok only moves on done or after start
    assert_ok_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(start)) |-> (chk_ok == $past(chk_ok)));

    // R2: start clears result outputs
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (!chk_ok && !done));

    // R3: addresses stay inside the grid
    assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < CELLS));

    // R3: back-to-back writes use consecutive addresses
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

    // R5: the checksum byte never writes
    assert_no_write_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && done));

endmodule

bind grid_checksum_rx grid_checksum_rx_chk #(.GRID_N(GRID_N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .done     (done),
    .chk_ok   (chk_ok)
);

// File: tb/tb_grid_checksum_rx.sv
module tb_grid_checksum_rx;

    localparam int N      = 4;
    localparam int CELLS  = N * N;
    localparam int ADDR_W = (CELLS > 1) ? $clog2(CELLS) : 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              done;
    logic              chk_ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    grid_checksum_rx #(.GRID_N(N)) dut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .chk_ok(chk_ok)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: position from a plain counter, sign from (r+c)%2
    int  m_phase = 0;
    int  m_idx   = 0;
    int  m_sum   = 0;
    bit  exp_wr_en = 0, exp_done = 0, exp_ok = 0;
    int  exp_addr = 0, exp_data = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_idx = 0; m_sum = 0;
            exp_wr_en <= 0; exp_done <= 0; exp_ok <= 0;
        end else begin
            exp_wr_en <= 0;
            exp_done  <= 0;
            if (start) begin
                m_phase = 1; m_idx = 0; m_sum = 0;
                exp_ok <= 0;
            end else if (in_valid) begin
                if (m_phase == 1) begin
                    exp_wr_en <= 1;
                    exp_addr  <= m_idx;
                    exp_data  <= int'(in_data);
                    if ((((m_idx / N) + (m_idx % N)) % 2) == 0) m_sum = m_sum + int'(in_data);
                    else                                        m_sum = m_sum - int'(in_data);
                    m_idx++;
                    if (m_idx == CELLS) m_phase = 2;
                end else if (m_phase == 2) begin
                    exp_done <= 1;
                    exp_ok   <= ((m_sum & 255) == int'(in_data));
                    m_phase = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(wr_en == exp_wr_en, "R3/R5/R7 wr_en", int'(wr_en), int'(exp_wr_en));
            if (exp_wr_en) begin
                check(int'(wr_addr) == exp_addr, "R3 wr_addr", int'(wr_addr), exp_addr);
                check(int'(wr_data) == exp_data, "R3 wr_data", int'(wr_data), exp_data);
            end
            check(done == exp_done, "R6 done", int'(done), int'(exp_done));
            check(chk_ok == exp_ok, "R6 chk_ok", int'(chk_ok), int'(exp_ok));
        end
    end

    function automatic int grid_sum(input int g[CELLS]);
        int s = 0;
        for (int i = 0; i < CELLS; i++)
            s = ((((i / N) + (i % N)) % 2) == 0) ? s + g[i] : s - g[i];
        return s & 255;
    endfunction

    task automatic put(input int b);
        in_valid = 1'b1;
        in_data  = 8'(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_frame(input int g[CELLS], input int ck, input bit gaps);
        pulse_start();
        for (int i = 0; i < CELLS; i++) begin
            put(g[i]);
            if (gaps && ($urandom_range(0, 2) == 0)) @(negedge clk);
        end
        put(ck);
    endtask

    int g[CELLS];

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!wr_en && !done && !chk_ok, "R1 reset outputs", int'({wr_en, done, chk_ok}), 0);

        // R1: idle bytes ignored
        for (int i = 0; i < 5; i++) put($urandom_range(0, 255));
        check(!wr_en && !done, "R1 idle ignores bytes", int'({wr_en, done}), 0);

        // R8: all-empty grid
        for (int i = 0; i < CELLS; i++) g[i] = 0;
        send_frame(g, 0, 0);
        check(done && chk_ok, "R8 empty grid checksum 0", int'({done, chk_ok}), 3);
        send_frame(g, 1, 0);
        check(done && !chk_ok, "R8 empty grid bad checksum", int'({done, chk_ok}), 2);

        // R4: sign at start of odd row, even side length
        for (int i = 0; i < CELLS; i++) g[i] = 0;
        g[N] = 5;
        send_frame(g, 251, 0);
        check(chk_ok == 1'b1, "R4 row1 col0 subtracted", int'(chk_ok), 1);
        g[N] = 0; g[N + 1] = 5;
        send_frame(g, 5, 0);
        check(chk_ok == 1'b1, "R4 row1 col1 added", int'(chk_ok), 1);
        g[N + 1] = 0; g[1] = 9;
        send_frame(g, 247, 0);
        check(chk_ok == 1'b1, "R4 row0 col1 subtracted", int'(chk_ok), 1);

        // R6: random grids, correct and corrupted checksums
        for (int t = 0; t < 12; t++) begin
            for (int i = 0; i < CELLS; i++)
                g[i] = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 255);
            send_frame(g, grid_sum(g), t[0]);
            check(chk_ok == 1'b1, "R6 random grid match", int'(chk_ok), 1);
            send_frame(g, grid_sum(g) ^ $urandom_range(1, 255), t[1]);
            check(chk_ok == 1'b0, "R6 random grid mismatch", int'(chk_ok), 0);
        end

        // R7: traffic after done is ignored and chk_ok holds
        for (int i = 0; i < CELLS; i++) g[i] = $urandom_range(0, 255);
        send_frame(g, grid_sum(g), 0);
        for (int i = 0; i < 6; i++) begin
            put($urandom_range(0, 255));
            check(!wr_en && !done, "R7 no activity after done", int'({wr_en, done}), 0);
        end
        check(chk_ok == 1'b1, "R6 chk_ok held", int'(chk_ok), 1);

        // R2: start mid-frame restarts at cell 0
        pulse_start();
        check(chk_ok == 1'b0, "R2 start clears chk_ok", int'(chk_ok), 0);
        for (int i = 0; i < 7; i++) put($urandom_range(0, 255));
        send_frame(g, grid_sum(g), 0);
        check(chk_ok == 1'b1, "R2 restart mid-frame", int'(chk_ok), 1);

        // R2: start overrides a byte in the same cycle
        start = 1'b1; in_valid = 1'b1; in_data = 8'd77;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        check(!wr_en, "R2 byte with start dropped", int'(wr_en), 0);
        for (int i = 0; i < CELLS; i++) put(g[i]);
        put(grid_sum(g));
        check(done && chk_ok, "R2 frame after start+byte", int'({done, chk_ok}), 3);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule